// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the operand address for a processor with a 24-bit address space. For each request it takes an addressing mode, a pointer register select, a data register select, a signed constant, the current pointer register values and the value of the selected data register. It returns the effective address. For the auto-increment and auto-decrement modes it also returns the updated pointer value, which the register file writes back.

Two modes use a pointer held in memory. For these the unit first forms a location. It then reads a 24-bit pointer from that location over a simple request/acknowledge read port, and the pointer it reads becomes the effective address. Mode and register combinations that are not allowed complete at once with an illegal flag. They change no register and start no memory read.

A request is accepted only while the unit is idle. Results are registered, `done` pulses for one cycle, and the result outputs keep their values until the next accepted request.

Top module: `ea_gen`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `illegal`, `wb_en` and `mem_req` are 0, and `ea`, `wb_sel` and `wb_val` are 0.
- R2: Mode code 0 (PC-relative) gives `ea` = `reg_p` + the sign-extended low 16 bits of `offset`, modulo 2^24.
- R3: Mode code 1 (absolute) gives `ea` = `offset`. Mode code 3 (constant indexed) gives `ea` = base + `offset`, with `offset` taken as a signed 24-bit value. The base is chosen by `idx_sel`: 0 is X, 1 is Y, 2 is S, 3 is P. All address sums wrap modulo 2^24.
- R4: Mode code 6 (register-offset direct) gives `ea` = base + the data offset, with base X, Y or S. The data offset is `dreg_val` sign-extended when `dreg_sel` is 2, 3, 4 or 5 and zero-extended otherwise, then cut to its low 24 bits. Base P is illegal.
- R5: Mode code 5 (auto step) takes X, Y or S. `auto_kind` selects the step: 0 pre-increment, 1 pre-decrement, 2 post-increment, 3 post-decrement. The step size is `step_code`+1 bytes. The pre kinds give `ea` equal to the updated value. The post kinds give `ea` equal to the old value. The unit sets `wb_en`=1, `wb_sel`=`idx_sel` and `wb_val`=the updated value. Base P is illegal.
- R6: Pre-increment or post-decrement on S, or any illegal combination, completes one cycle after start with `illegal`=1, `wb_en`=0, `ea`=0 and no memory request.
- R7: Mode code 2 reads the pointer at `offset`. Mode code 4 reads it at base + `offset`. Mode code 7 reads it at base + data offset, where the base must be X or Y; S or P is illegal. In each case `ea` is the 24-bit `mem_rdata` returned.
- R8: During a read, `mem_req` stays high with `mem_addr` unchanged until `mem_ack` is sampled high. It is low from the next cycle on.
- R9: `done` is a one-cycle pulse. For direct and illegal cases it appears in the cycle after start. For reads it appears in the cycle after `mem_ack` is sampled.
- R10: Result outputs stay unchanged until the next accepted start, and a start raised while a read is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request, accepted when idle |
| mode | input | 3 | Addressing mode code |
| idx_sel | input | 2 | Pointer register select (X, Y, S, P) |
| dreg_sel | input | 3 | Data register number, 0 to 7 |
| auto_kind | input | 2 | Auto step kind |
| step_code | input | 2 | Step size minus one |
| offset | input | 24 | Constant, displacement or absolute address |
| reg_x | input | 24 | X value |
| reg_y | input | 24 | Y value |
| reg_s | input | 24 | S value |
| reg_p | input | 24 | P value |
| dreg_val | input | 32 | Value of the selected data register |
| mem_ack | input | 1 | Read acknowledge |
| mem_rdata | input | 24 | Pointer read from memory |
| done | output | 1 | Result valid pulse |
| ea | output | 24 | Effective address |
| illegal | output | 1 | Illegal mode/register combination |
| wb_en | output | 1 | Pointer write-back valid |
| wb_sel | output | 2 | Pointer register to write |
| wb_val | output | 24 | Updated pointer value |
| mem_req | output | 1 | Read request |
| mem_addr | output | 24 | Read location |

## Verification
A wrong phase register shows at the ports within one cycle. It appears as a `mem_req` that drops too early or never rises, or as a `done` that comes too early, too late or for more than one cycle. A wrong sum or extension lands in `ea`, `wb_val` or `mem_addr` in the cycle `done` or `mem_req` rises. The bench compares every output with its reference on every clock, including idle cycles, so a result that drifts while it should hold is caught one cycle after it changes.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    typedef enum logic [2:0] {
        MD_PCREL    = 3'd0,
        MD_ABS      = 3'd1,
        MD_ABS_IND  = 3'd2,
        MD_CIDX     = 3'd3,
        MD_CIDX_IND = 3'd4,
        MD_AUTO     = 3'd5,
        MD_RIDX     = 3'd6,
        MD_RIDX_IND = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        PR_X = 2'd0,
        PR_Y = 2'd1,
        PR_S = 2'd2,
        PR_P = 2'd3
    } preg_e;

    typedef enum logic [1:0] {
        AK_PRE_INC  = 2'd0,
        AK_PRE_DEC  = 2'd1,
        AK_POST_INC = 2'd2,
        AK_POST_DEC = 2'd3
    } akind_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_FETCH = 1'b1
    } phase_e;

endpackage

// File: rtl/ea_gen_dext.sv
module ea_gen_dext #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 24
) (
    input  logic [DW-1:0] dval,
    input  logic [2:0]    dsel,
    output logic [AW-1:0] dext
);
    // registers 2..5 carry signed offsets
    logic is_signed;
    assign is_signed = (dsel >= 3'd2) && (dsel <= 3'd5);

    generate
        if (AW > DW) begin : g_pad
            localparam int unsigned PAD = AW - DW;
            assign dext = {{PAD{is_signed & dval[DW-1]}}, dval};
        end else begin : g_cut
            assign dext = dval[AW-1:0];
            // upper bits only matter for the extension rule, which truncation discards
            logic unused_hi;
            assign unused_hi = ^{is_signed, dval};
        end
    endgenerate

endmodule

// File: rtl/ea_gen_calc.sv
module ea_gen_calc
    import ea_gen_pkg::*;
#(
    parameter int unsigned AW     = 24,
    parameter int unsigned DISP_W = 16
) (
    input  logic [2:0]    mode,
    input  logic [1:0]    idx_sel,
    input  logic [1:0]    auto_kind,
    input  logic [1:0]    step_code,
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] reg_x,
    input  logic [AW-1:0] reg_y,
    input  logic [AW-1:0] reg_s,
    input  logic [AW-1:0] reg_p,
    input  logic [AW-1:0] dext,
    output logic          legal,
    output logic          indirect,
    output logic [AW-1:0] addr,
    output logic          wb_en,
    output logic [1:0]    wb_sel,
    output logic [AW-1:0] wb_val
);
    localparam int unsigned DPAD = AW - DISP_W;

    mode_e         md;
    preg_e         ps;
    akind_e        ak;
    logic [AW-1:0] base;
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] step;
    logic [AW-1:0] stepped;
    logic          s_bad_kind;

    always_comb begin
        md = mode_e'(mode);
        ps = preg_e'(idx_sel);
        ak = akind_e'(auto_kind);

        unique case (ps)
            PR_X:    base = reg_x;
            PR_Y:    base = reg_y;
            PR_S:    base = reg_s;
            default: base = reg_p;
        endcase

        disp_ext = {{DPAD{offset[DISP_W-1]}}, offset[DISP_W-1:0]};
        step     = AW'(step_code) + AW'(1);
        if ((ak == AK_PRE_DEC) || (ak == AK_POST_DEC)) begin
            stepped = base - step;
        end else begin
            stepped = base + step;
        end
        s_bad_kind = (ps == PR_S) && ((ak == AK_PRE_INC) || (ak == AK_POST_DEC));

        legal    = 1'b1;
        indirect = 1'b0;
        addr     = '0;
        wb_en    = 1'b0;
        wb_sel   = 2'd0;
        wb_val   = '0;

        unique case (md)
            MD_PCREL: begin
                addr = reg_p + disp_ext;
            end
            MD_ABS: begin
                addr = offset;
            end
            MD_ABS_IND: begin
                addr     = offset;
                indirect = 1'b1;
            end
            MD_CIDX: begin
                addr = base + offset;
            end
            MD_CIDX_IND: begin
                addr     = base + offset;
                indirect = 1'b1;
            end
            MD_AUTO: begin
                legal = (ps != PR_P) && !s_bad_kind;
                if ((ak == AK_PRE_INC) || (ak == AK_PRE_DEC)) begin
                    addr = stepped;
                end else begin
                    addr = base;
                end
                wb_en  = 1'b1;
                wb_sel = idx_sel;
                wb_val = stepped;
            end
            MD_RIDX: begin
                legal = (ps != PR_P);
                addr  = base + dext;
            end
            default: begin
                legal    = (ps == PR_X) || (ps == PR_Y);
                addr     = base + dext;
                indirect = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int unsigned AW     = 24,
    parameter int unsigned DW     = 32,
    parameter int unsigned DISP_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [1:0]    idx_sel,
    input  logic [2:0]    dreg_sel,
    input  logic [1:0]    auto_kind,
    input  logic [1:0]    step_code,
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] reg_x,
    input  logic [AW-1:0] reg_y,
    input  logic [AW-1:0] reg_s,
    input  logic [AW-1:0] reg_p,
    input  logic [DW-1:0] dreg_val,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic          illegal,
    output logic          wb_en,
    output logic [1:0]    wb_sel,
    output logic [AW-1:0] wb_val,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr
);
    typedef struct packed {
        phase_e        phase;
        logic          done;
        logic [AW-1:0] ea;
        logic          ill;
        logic          wb_en;
        logic [1:0]    wb_sel;
        logic [AW-1:0] wb_val;
        logic          req;
        logic [AW-1:0] maddr;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0] dext;
    logic          c_legal;
    logic          c_ind;
    logic [AW-1:0] c_addr;
    logic          c_wb_en;
    logic [1:0]    c_wb_sel;
    logic [AW-1:0] c_wb_val;

    ea_gen_dext #(.DW(DW), .AW(AW)) u_dext (
        .dval (dreg_val),
        .dsel (dreg_sel),
        .dext (dext)
    );

    ea_gen_calc #(.AW(AW), .DISP_W(DISP_W)) u_calc (
        .mode      (mode),
        .idx_sel   (idx_sel),
        .auto_kind (auto_kind),
        .step_code (step_code),
        .offset    (offset),
        .reg_x     (reg_x),
        .reg_y     (reg_y),
        .reg_s     (reg_s),
        .reg_p     (reg_p),
        .dext      (dext),
        .legal     (c_legal),
        .indirect  (c_ind),
        .addr      (c_addr),
        .wb_en     (c_wb_en),
        .wb_sel    (c_wb_sel),
        .wb_val    (c_wb_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.ea     = '0;
                    st_d.ill    = 1'b0;
                    st_d.wb_en  = 1'b0;
                    st_d.wb_sel = 2'd0;
                    st_d.wb_val = '0;
                    if (!c_legal) begin
                        st_d.done = 1'b1;
                        st_d.ill  = 1'b1;
                    end else if (c_ind) begin
                        st_d.phase = PH_FETCH;
                        st_d.req   = 1'b1;
                        st_d.maddr = c_addr;
                    end else begin
                        st_d.done = 1'b1;
                        st_d.ea   = c_addr;
                        if (c_wb_en) begin
                            st_d.wb_en  = 1'b1;
                            st_d.wb_sel = c_wb_sel;
                            st_d.wb_val = c_wb_val;
                        end
                    end
                end
            end
            default: begin
                if (mem_ack) begin
                    st_d.phase = PH_IDLE;
                    st_d.req   = 1'b0;
                    st_d.done  = 1'b1;
                    st_d.ea    = mem_rdata;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done     = st_q.done;
    assign ea       = st_q.ea;
    assign illegal  = st_q.ill;
    assign wb_en    = st_q.wb_en;
    assign wb_sel   = st_q.wb_sel;
    assign wb_val   = st_q.wb_val;
    assign mem_req  = st_q.req;
    assign mem_addr = st_q.maddr;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R8
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req && done); // R9
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R9
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wb_en && !mem_req && (ea == '0)); // R6
    AST_WB_NOT_P: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_sel != 2'd3)); // R5
    AST_EA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done && !$past(start) |-> $stable(ea) && $stable(wb_val)); // R10

endmodule

// File: tb/ea_gen_bench.sv
`timescale 1ns/1ps
module ea_gen_bench;
    localparam longint MASK = 64'hFFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  idx_sel = '0;
    logic [2:0]  dreg_sel = '0;
    logic [1:0]  auto_kind = '0;
    logic [1:0]  step_code = '0;
    logic [23:0] offset = '0;
    logic [23:0] reg_x = '0, reg_y = '0, reg_s = '0, reg_p = '0;
    logic [31:0] dreg_val = '0;
    logic        mem_ack = 1'b0;
    logic [23:0] mem_rdata = '0;
    logic        done, illegal, wb_en, mem_req;
    logic [23:0] ea, wb_val, mem_addr;
    logic [1:0]  wb_sel;

    always #2 clk = ~clk;

    ea_gen u_ea_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx_sel(idx_sel),
        .dreg_sel(dreg_sel), .auto_kind(auto_kind), .step_code(step_code),
        .offset(offset), .reg_x(reg_x), .reg_y(reg_y), .reg_s(reg_s), .reg_p(reg_p),
        .dreg_val(dreg_val), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .ea(ea), .illegal(illegal), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_val(wb_val), .mem_req(mem_req), .mem_addr(mem_addr)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    function automatic longint mem_fn(input longint a);
        return (a * 181 + 64'h3C1A57) & MASK;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model
    bit     m_done, m_ill, m_wben, m_req, m_busy;
    longint m_ea, m_wbval, m_maddr;
    int     m_wbsel;

    always @(posedge clk) begin
        longint base, dx, so, rel, a, nv;
        bit ok, ind, wb;
        if (!rst_n) begin
            m_done = 0; m_ill = 0; m_wben = 0; m_req = 0; m_busy = 0;
            m_ea = 0; m_wbval = 0; m_maddr = 0; m_wbsel = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (mem_ack) begin
                    m_ea = mem_fn(m_maddr); m_done = 1; m_busy = 0; m_req = 0;
                end
            end else if (start) begin
                base = (idx_sel == 0) ? longint'(reg_x) : (idx_sel == 1) ? longint'(reg_y) :
                       (idx_sel == 2) ? longint'(reg_s) : longint'(reg_p);
                dx  = (dreg_sel >= 2 && dreg_sel <= 5) ? longint'($signed(dreg_val)) : longint'(dreg_val);
                so  = longint'($signed(offset));
                rel = longint'($signed(offset[15:0]));
                ok = 1; ind = 0; wb = 0; a = 0; nv = 0;
                case (mode)
                    3'd0: a = longint'(reg_p) + rel;
                    3'd1: a = longint'(offset);
                    3'd2: begin a = longint'(offset); ind = 1; end
                    3'd3: a = base + so;
                    3'd4: begin a = base + so; ind = 1; end
                    3'd5: begin
                        if (idx_sel == 3 || (idx_sel == 2 && (auto_kind == 0 || auto_kind == 3))) ok = 0;
                        nv = (auto_kind == 0 || auto_kind == 2) ? base + step_code + 1 : base - step_code - 1;
                        a  = (auto_kind < 2) ? nv : base;
                        wb = 1;
                    end
                    3'd6: begin ok = (idx_sel != 3); a = base + dx; end
                    default: begin ok = (idx_sel < 2); a = base + dx; ind = 1; end
                endcase
                a = a & MASK; nv = nv & MASK;
                m_ea = 0; m_ill = 0; m_wben = 0; m_wbsel = 0; m_wbval = 0;
                if (!ok) begin
                    m_done = 1; m_ill = 1;
                end else if (ind) begin
                    m_busy = 1; m_req = 1; m_maddr = a;
                end else begin
                    m_done = 1; m_ea = a;
                    if (wb) begin m_wben = 1; m_wbsel = idx_sel; m_wbval = nv; end
                end
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(done == m_done, "R9", "done", done, m_done);
            chk(mem_req == m_req, "R8", "mem_req", mem_req, m_req);
            if (m_req) chk(mem_addr == m_maddr, "R8", "mem_addr", mem_addr, m_maddr);
            chk(illegal == m_ill, cur_tag, "illegal", illegal, m_ill);
            chk(ea == m_ea, cur_tag, "ea", ea, m_ea);
            chk(wb_en == m_wben, cur_tag, "wb_en", wb_en, m_wben);
            if (m_wben) begin
                chk(wb_sel == m_wbsel, cur_tag, "wb_sel", wb_sel, m_wbsel);
                chk(wb_val == m_wbval, cur_tag, "wb_val", wb_val, m_wbval);
            end
        end
    end

    // memory responder with 0..2 cycle latency
    int lat = -1;
    always @(negedge clk) begin
        if (!rst_n || mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (lat < 0) lat = $urandom % 3;
            if (lat == 0) begin
                mem_ack = 1'b1; mem_rdata = 24'(mem_fn(longint'(mem_addr))); lat = -1;
            end else begin
                lat--;
            end
        end
    end

    task automatic do_op(input int md, input int ps, input int ds, input int ak,
                         input int sc, input longint off, input string tag, input bit inject);
        @(negedge clk);
        cur_tag = tag;
        mode = 3'(md); idx_sel = 2'(ps); dreg_sel = 3'(ds); auto_kind = 2'(ak);
        step_code = 2'(sc); offset = 24'(off); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject && mem_req) begin
            cur_tag = "R10";
            mode = 3'd1; offset = 24'h123456; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 20 && !done && mem_req; i++) @(negedge clk);
        repeat ($urandom % 2) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !wb_en && !illegal, "R1", "flags in reset",
            {done, mem_req, wb_en, illegal}, 0);
        chk(ea == 0 && wb_val == 0 && wb_sel == 0, "R1", "values in reset", ea, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req && ea == 0, "R1", "after release", ea, 0);

        reg_x = 24'h001000; reg_y = 24'hFFFFFE; reg_s = 24'h000800; reg_p = 24'h000010;
        do_op(0, 0, 0, 0, 0, 24'h008000, "R2", 0);   // P - 32768 wraps
        do_op(0, 0, 0, 0, 0, 24'hAB7FFF, "R2", 0);   // high bits ignored
        do_op(1, 0, 0, 0, 0, 24'hFE0034, "R3", 0);
        do_op(3, 0, 0, 0, 0, 24'hFFFFFC, "R3", 0);   // X - 4
        do_op(3, 1, 0, 0, 0, 24'h000005, "R3", 0);   // Y wraps
        do_op(3, 3, 0, 0, 0, 24'h800000, "R3", 0);   // P + most negative
        dreg_val = 32'hFFFFFFF0;
        do_op(6, 1, 2, 0, 0, 0, "R4", 0);             // signed D2
        dreg_val = 32'h80000010;
        do_op(6, 0, 7, 0, 0, 0, "R4", 0);             // unsigned D7
        do_op(6, 2, 0, 0, 0, 0, "R4", 0);
        do_op(6, 3, 1, 0, 0, 0, "R4", 0);             // P illegal
        for (int k = 0; k < 4; k++) do_op(5, 0, 0, k, k, 0, "R5", 0);
        do_op(5, 1, 0, 2, 3, 0, "R5", 0);             // Y post-inc wraps
        do_op(5, 3, 0, 2, 0, 0, "R5", 0);             // P illegal
        do_op(5, 2, 0, 2, 2, 0, "R5", 0);             // S post-inc legal
        do_op(5, 2, 0, 1, 1, 0, "R5", 0);             // S pre-dec legal
        do_op(5, 2, 0, 0, 0, 0, "R6", 0);             // S pre-inc illegal
        do_op(5, 2, 0, 3, 3, 0, "R6", 0);             // S post-dec illegal
        do_op(2, 0, 0, 0, 0, 24'hFD0012, "R7", 0);
        do_op(4, 1, 0, 0, 0, 24'h000004, "R7", 0);
        dreg_val = 32'h00000100;
        do_op(7, 0, 1, 0, 0, 0, "R7", 0);
        do_op(7, 2, 1, 0, 0, 0, "R7", 0);             // S illegal
        do_op(7, 3, 1, 0, 0, 0, "R7", 0);             // P illegal
        do_op(2, 0, 0, 0, 0, 24'h00ABCD, "R10", 1);   // start ignored while reading
        do_op(4, 3, 0, 0, 0, 24'h7FFFFF, "R10", 1);

        for (int n = 0; n < 600; n++) begin
            int md;
            string t;
            md = $urandom % 8;
            reg_x = 24'($urandom); reg_y = 24'($urandom);
            reg_s = 24'($urandom); reg_p = 24'($urandom);
            dreg_val = $urandom;
            case (md)
                0: t = "R2";
                1, 3: t = "R3";
                5: t = "R5";
                6: t = "R4";
                default: t = "R7";
            endcase
            do_op(md, $urandom % 4, $urandom % 8, $urandom % 4, $urandom % 4,
                  longint'($urandom), t, (n % 7) == 0);
        end
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule